// File: doc/BRIEF.md
# Floppy Controller Command Sequencer

This block is the host-facing command sequencer of a floppy disk controller. The host talks to it through one status read port and one byte-wide data port. A command starts with an opcode byte. Any parameter bytes follow on the same port. A stub execution engine then runs for a fixed interval. The host then reads a fixed number of result bytes back through the data port. After that the sequencer returns to waiting for the next command. A small decoder on the opcode supplies the parameter and result counts, so the host always knows how many bytes remain.

The status byte tells the host what to do next:
- A ready flag gates every byte transfer. It drops for `LATENCY` cycles after each transfer, so the host paces itself by polling this flag instead of using fixed delays.
- A direction flag shows whether the controller expects a byte or holds one.
- A busy flag spans the whole command, from the opcode to the last result byte.
- An execution flag marks the execution phase.

Host writes use a valid/ready handshake. The host holds `wr_valid` and `wr_data` until it sees `wr_ready` at a rising edge. A byte offered while `wr_ready` is low is not taken and has no effect. `wr_ready` never depends on `wr_valid`. Reads are strobes. `rd_data` shows the current result byte only while a read is allowed. A strobe at any other time returns 0 and is ignored.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After reset, `status` is 0x80, `rd_data` is 0 and `wr_ready` is 1.
- R2: The status bits are: bit 7 = byte transfer allowed (RQM), bit 6 = controller holds a byte for the host (DIO), bit 5 = execution phase (NDMA), bit 4 = command busy. Bits 3..0 are always 0.
- R3: A write is accepted only at a rising edge where `wr_valid` and `wr_ready` are both 1. `wr_ready` is 1 exactly when RQM=1 and DIO=0. A write offered during a pacing gap, the execution phase or the result phase is ignored and does not change the byte counts.
- R4: After a byte is accepted or read, RQM is 0 for exactly `LATENCY` cycles before it returns. This holds unless the execution phase intervenes.
- R5: Only opcode bits 4..0 select the command. The (parameter, result) counts are: 0x03 → (2,0), 0x04 → (1,1), 0x06 → (8,7), 0x07 → (1,0), 0x08 → (0,2), 0x0F → (2,0).
- R6: After the last byte of a valid command (the opcode if it takes no parameters), NDMA=1 and BUSY=1 for exactly `EXEC_CYCLES` cycles. RQM stays 0 during that time. NDMA is 0 once the result phase begins.
- R7: In the result phase, whenever RQM=1 the status is 0xD0. Result byte i (counting from 0) has the value {i[3:0], opcode[3:0]}.
- R8: While RQM=0, `rd_data` is 0 and a read strobe does not advance the result index.
- R9: In the cycle after the last result byte is read, BUSY, DIO and NDMA are 0. `LATENCY` cycles later the status is 0x80.
- R10: An opcode outside the table takes no parameters and has no execution phase. It returns exactly one result byte, 0x80.
- R11: A valid command with zero result bytes returns to the idle state (BUSY=0, DIO=0) right after its execution phase.
- R12: BUSY rises in the cycle after the opcode byte is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host offers a command or parameter byte |
| wr_data | input | 8 | Byte offered by the host |
| wr_ready | output | 1 | Controller takes the offered byte at this edge |
| rd_en | input | 1 | Host read strobe on the data port |
| rd_data | output | 8 | Current result byte, or 0 when reading is not allowed |
| status | output | 8 | Main status byte (RQM, DIO, NDMA, BUSY) |

## Verification
Every status change appears in the cycle after the edge that caused it:
- RQM falls in the cycle after an accepted byte and returns exactly `LATENCY` cycles later.
- NDMA holds for `EXEC_CYCLES` cycles starting the cycle after the final command byte.
- `rd_data` is combinational and valid in the same cycle RQM and DIO are set.

The bench drives inputs and samples outputs on the falling edge. It counts whole cycles from each accepted byte to each flag change and compares the counts with the parameters. During every gap it holds stray writes and read strobes, then confirms that the next result value and the byte counts are unaffected.

// File: rtl/fdc_cmd_pkg.sv
package fdc_cmd_pkg;

  localparam int CNT_W = 4;

  typedef enum logic [1:0] {
    PH_CMD    = 2'd0,
    PH_PARAM  = 2'd1,
    PH_EXEC   = 2'd2,
    PH_RESULT = 2'd3
  } phase_e;

  typedef struct packed {
    logic             valid;
    logic [CNT_W-1:0] n_param;
    logic [CNT_W-1:0] n_result;
  } cmd_info_t;

  localparam logic [4:0] OP_SETUP = 5'h03;
  localparam logic [4:0] OP_QUERY = 5'h04;
  localparam logic [4:0] OP_FETCH = 5'h06;
  localparam logic [4:0] OP_HOME  = 5'h07;
  localparam logic [4:0] OP_POLL  = 5'h08;
  localparam logic [4:0] OP_MOVE  = 5'h0F;

  localparam logic [7:0] BAD_OPCODE_CODE = 8'h80;

endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
  import fdc_cmd_pkg::*;
(
  input  logic [4:0] opcode,
  output cmd_info_t  info
);
  always_comb begin
    info = '{valid: 1'b1, n_param: '0, n_result: '0};
    unique case (opcode)
      OP_SETUP: info.n_param = CNT_W'(2);
      OP_QUERY: begin info.n_param = CNT_W'(1); info.n_result = CNT_W'(1); end
      OP_FETCH: begin info.n_param = CNT_W'(8); info.n_result = CNT_W'(7); end
      OP_HOME:  info.n_param = CNT_W'(1);
      OP_POLL:  info.n_result = CNT_W'(2);
      OP_MOVE:  info.n_param = CNT_W'(2);
      default:  begin info.valid = 1'b0; info.n_result = CNT_W'(1); end
    endcase
  end
endmodule

// File: rtl/fdc_byte_pacer.sv
module fdc_byte_pacer #(
  parameter int LATENCY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic ready
);
  localparam int W = (LATENCY < 1) ? 1 : $clog2(LATENCY + 1);
  localparam logic [W-1:0] LOAD = W'(LATENCY);

  logic [W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            gap_q <= '0;
    else if (kick)         gap_q <= LOAD;
    else if (gap_q != '0)  gap_q <= gap_q - W'(1);
  end

  assign ready = (gap_q == '0);
endmodule

// File: rtl/fdc_result_stub.sv
module fdc_result_stub
  import fdc_cmd_pkg::*;
(
  input  logic             enable,
  input  logic             cmd_ok,
  input  logic [3:0]       op_nib,
  input  logic [CNT_W-1:0] idx,
  output logic [7:0]       data
);
  always_comb begin
    if (!enable)      data = 8'h00;
    else if (!cmd_ok) data = BAD_OPCODE_CODE;
    else              data = {idx[3:0], op_nib};
  end
endmodule

// File: rtl/fdc_phase_fsm.sv
module fdc_phase_fsm
  import fdc_cmd_pkg::*;
#(
  parameter int EXEC_CYCLES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic             rd_fire,
  input  logic [3:0]       op_nib_in,
  input  cmd_info_t        info_in,
  output phase_e           phase,
  output logic [3:0]       op_nib,
  output cmd_info_t        info_q,
  output logic [CNT_W-1:0] idx
);
  localparam int EW = (EXEC_CYCLES < 2) ? 1 : $clog2(EXEC_CYCLES);
  localparam logic [EW-1:0] EXEC_LAST = EW'(EXEC_CYCLES - 1);

  logic [CNT_W-1:0] left_q;
  logic [EW-1:0]    ecnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_CMD;
      op_nib <= '0;
      info_q <= '0;
      idx    <= '0;
      left_q <= '0;
      ecnt_q <= '0;
    end else begin
      unique case (phase)
        PH_CMD: if (wr_fire) begin
          op_nib <= op_nib_in;
          info_q <= info_in;
          idx    <= '0;
          left_q <= info_in.n_param;
          ecnt_q <= EXEC_LAST;
          if (!info_in.valid)              phase <= PH_RESULT;
          else if (info_in.n_param != '0)  phase <= PH_PARAM;
          else                             phase <= PH_EXEC;
        end
        PH_PARAM: if (wr_fire) begin
          if (left_q == CNT_W'(1)) phase  <= PH_EXEC;
          else                     left_q <= left_q - CNT_W'(1);
        end
        PH_EXEC: begin
          if (ecnt_q == '0)
            phase <= (info_q.n_result != '0) ? PH_RESULT : PH_CMD;
          else
            ecnt_q <= ecnt_q - EW'(1);
        end
        PH_RESULT: if (rd_fire) begin
          if (idx == info_q.n_result - CNT_W'(1)) phase <= PH_CMD;
          else                                    idx   <= idx + CNT_W'(1);
        end
        default: phase <= PH_CMD;
      endcase
    end
  end
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdc_cmd_pkg::*;
#(
  parameter int LATENCY     = 3,
  parameter int EXEC_CYCLES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       wr_ready,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic [7:0] status
);
  cmd_info_t        dec_info;
  cmd_info_t        info_q;
  phase_e           phase;
  logic [3:0]       op_nib;
  logic [CNT_W-1:0] idx;
  logic             pace_ok, rqm, dio, ndma, busy;
  logic             wr_fire, rd_fire;
  logic             unused_mode_bits;

  assign unused_mode_bits = ^wr_data[7:5];

  fdc_cmd_decode u_decode (
    .opcode (wr_data[4:0]),
    .info   (dec_info)
  );

  fdc_byte_pacer #(.LATENCY(LATENCY)) u_pacer (
    .clk   (clk),
    .rst_n (rst_n),
    .kick  (wr_fire | rd_fire),
    .ready (pace_ok)
  );

  fdc_phase_fsm #(.EXEC_CYCLES(EXEC_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (wr_fire),
    .rd_fire   (rd_fire),
    .op_nib_in (wr_data[3:0]),
    .info_in   (dec_info),
    .phase     (phase),
    .op_nib    (op_nib),
    .info_q    (info_q),
    .idx       (idx)
  );

  assign dio      = (phase == PH_RESULT);
  assign ndma     = (phase == PH_EXEC);
  assign busy     = (phase != PH_CMD);
  assign rqm      = pace_ok && !ndma;
  assign wr_ready = rqm && !dio;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_en && rqm && dio;
  assign status   = {rqm, dio, ndma, busy, 4'b0000};

  fdc_result_stub u_result (
    .enable (rqm && dio),
    .cmd_ok (info_q.valid),
    .op_nib (op_nib),
    .idx    (idx),
    .data   (rd_data)
  );
endmodule

// File: rtl/fdc_cmd_seq_chk.sv
module fdc_cmd_seq_chk #(
  parameter int LATENCY = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] rd_data,
  input logic [7:0] status
);
  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[3:0] == 4'h0);

  a_r6_exec_blocks_rqm: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] |-> (!status[7] && status[4] && !status[6]));

  a_r4_rqm_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ((LATENCY > 0) && wr_valid && wr_ready) |=> !status[7]);

  a_r8_zero_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    !status[7] |-> (rd_data == 8'h00));

  a_r7_result_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> status[4]);

  a_r9_busy_end_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[4]) |-> (!status[6] && !status[5]));

  a_r12_busy_on_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !status[4]) |=> status[4]);
endmodule

bind fdc_cmd_seq fdc_cmd_seq_chk #(.LATENCY(LATENCY)) u_chk (.*);

// File: tb/tb_fdc_cmd_seq.sv
module tb_fdc_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LAT  = 3;
  localparam int EXEC = 5;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wr_ready;
  logic rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] status;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_cmd_seq #(.LATENCY(LAT), .EXEC_CYCLES(EXEC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_en(rd_en), .rd_data(rd_data), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void cmd_table(input logic [7:0] op, output bit v,
                                    output int np, output int nr);
    v = 1'b1; np = 0; nr = 0;
    case (op[4:0])
      5'h03: np = 2;
      5'h04: begin np = 1; nr = 1; end
      5'h06: begin np = 8; nr = 7; end
      5'h07: np = 1;
      5'h08: nr = 2;
      5'h0F: np = 2;
      default: begin v = 1'b0; nr = 1; end
    endcase
  endfunction

  task automatic wait_rqm();
    int n = 0;
    while (!status[7] && n < 200) begin n++; @(negedge clk); end
    chk(status[7] == 1'b1, "R4 rqm returns", status[7], 1);
  endtask

  task automatic put_byte(input logic [7:0] b);
    wait_rqm();
    chk(status[6] == 1'b0 && wr_ready == 1'b1, "R3 ready for write", {status[6], wr_ready}, 1);
    wr_valid = 1'b1; wr_data = b;
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Holds a stray write (and optionally a read strobe) during a pacing gap.
  task automatic gap(input bit hold_rd, input string req);
    int n = 0;
    wr_valid = 1'b1; wr_data = 8'hEE; rd_en = hold_rd;
    while (!status[7] && n < 64) begin
      if (hold_rd) chk(rd_data == 8'h00, "R8 zero while blocked", rd_data, 0);
      n++; @(negedge clk);
    end
    wr_valid = 1'b0; rd_en = 1'b0;
    chk(n == LAT, req, n, LAT);
  endtask

  task automatic read_results(input logic [7:0] op, input bit v, input int nr);
    for (int i = 0; i < nr; i++) begin
      logic [7:0] exp_b;
      exp_b = v ? {4'(i), op[3:0]} : 8'h80;
      wait_rqm();
      chk(status == 8'hD0, "R7 result status", status, 8'hD0);
      chk(rd_data == exp_b, v ? "R7 result value" : "R10 invalid code", rd_data, exp_b);
      rd_en = 1'b1;
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
      if (i < nr - 1) begin
        gap(1'b1, "R4 gap after read");
      end else begin
        chk(status[6:4] == 3'b000, "R9 clean after last read", status, 0);
        gap(1'b0, "R9 idle gap");
        chk(status == 8'h80, "R9 back to idle", status, 8'h80);
      end
    end
  endtask

  task automatic exec_phase(input logic [7:0] op, input int nr);
    int n = 0;
    while (status[5] && n < 1000) begin n++; @(negedge clk); end
    chk(n == EXEC, "R6 exec length", n, EXEC);
    chk(status[5] == 1'b0, "R6 ndma clear", status[5], 0);
    if (nr == 0) begin
      chk(status[4] == 1'b0 && status[6] == 1'b0, "R11 idle after exec", status, 8'h80);
      wait_rqm();
      chk(status == 8'h80, "R11 idle status", status, 8'h80);
    end else begin
      read_results(op, 1'b1, nr);
    end
  endtask

  task automatic run_cmd(input logic [7:0] op);
    bit v; int np, nr;
    cmd_table(op, v, np, nr);
    wait_rqm();
    chk(status == 8'h80, "R9 idle before command", status, 8'h80);
    put_byte(op);
    chk(status[4] == 1'b1, "R12 busy after opcode", status[4], 1);
    if (!v) begin
      chk(status[5] == 1'b0 && status[6] == 1'b1, "R10 straight to result", status, 8'h50);
      gap(1'b0, "R4 gap after opcode");
      read_results(op, 1'b0, 1);
    end else if (np == 0) begin
      chk(status[5] == 1'b1, "R6 exec after opcode", status[5], 1);
      exec_phase(op, nr);
    end else begin
      chk(status == 8'h10, "R5 param phase", status, 8'h10);
      gap(1'b0, "R4 gap after opcode");
      for (int p = 1; p <= np; p++) begin
        put_byte(op ^ 8'(p));
        if (p < np) begin
          chk(status[5] == 1'b0, "R5 param count", status[5], 0);
          gap(1'b0, "R3 R4 gap after param");
        end else begin
          chk(status[5] == 1'b1, "R5 exec after last param", status[5], 1);
        end
      end
      exec_phase(op, nr);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 8'h80, "R1 reset status", status, 8'h80);
    chk(rd_data == 8'h00, "R1 reset rd_data", rd_data, 0);
    chk(wr_ready == 1'b1, "R1 reset wr_ready", wr_ready, 1);
    chk(status[3:0] == 4'h0, "R2 low bits", status[3:0], 0);
    // stray read in idle has no effect
    rd_en = 1'b1; @(posedge clk); @(negedge clk); rd_en = 1'b0;
    chk(status == 8'h80 && rd_data == 8'h00, "R8 idle read ignored", status, 8'h80);
    for (int op = 0; op < 32; op++) run_cmd(8'(op));
    for (int op = 0; op < 32; op++) run_cmd(8'(op) | 8'hE0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1..all actual=%0d cycles expected=fewer", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule